// File: doc/BRIEF.md
# Nibble-Parallel CRC-5 Generator

This block keeps a running 5-bit cyclic redundancy check over a stream of 4-bit data words. The generator polynomial is x^5 + x^2 + 1. A serial shift register handles one bit per clock. This block takes a whole nibble in every clock in which its strobe is high. In that clock it works out the next 5-bit state from the current state and the four new bits in one pass of XOR logic.

A packet starts with a one-cycle start pulse, which puts the state back to its seed of all ones. After that, each strobed nibble is folded into the state. The check value can be read from the output at any time. Framing, bit stuffing and sending the check value all belong to the logic around the block.

Top module: `crc5n_gen`

## Requirements
- R1: While `rst_i` is sampled high at a rising edge, the state register loads 5'h1F, and `crc_o` shows 5'h1F after that edge.
- R2: When `init_i` is sampled high with `rst_i` low, the state loads 5'h1F. `init_i` has priority over `valid_i`, so a nibble presented in the same cycle is discarded.
- R3: When `rst_i`, `init_i` and `valid_i` are all low at an edge, `crc_o` keeps its previous value.
- R4: When `valid_i` is high with `rst_i` and `init_i` low, the new state equals four steps of the serial shift register for x^5+x^2+1. The steps take the data bits most significant first (`data_i[3]`, then `[2]`, `[1]`, `[0]`). Each step uses feedback fb = state[4] ^ bit and produces next = {state[3], state[2], state[1] ^ fb, state[0], fb}.
- R5: The nibble update is the fixed XOR set n0 = c1^c4^d0^d3, n1 = c2^d1, n2 = c1^c3^c4^d0^d2^d3, n3 = c2^c4^d1^d3, n4 = c0^c3^d2. For example, seed 5'h1F with data 4'h0 gives 5'h06, and seed 5'h1F with data 4'hF gives 5'h10.
- R6: `crc_o` is driven straight from the state register, so it changes one rising edge after the strobed nibble and never combinationally from the inputs.
- R7: `data_i` has no effect on `crc_o` in cycles where `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset; seeds the state with all ones |
| init_i | input | 1 | Start-of-packet pulse; reseeds the state with all ones |
| valid_i | input | 1 | Strobe: the nibble on `data_i` is absorbed this cycle |
| data_i | input | 4 | Data nibble; bit 3 enters the shift order first |
| crc_o | output | 5 | Current CRC state |

## Verification
The checker watches four behaviours at every rising edge:
- reseeding after reset;
- reseeding after the start pulse;
- holding the state in idle cycles;
- agreement of each nibble update with a bit-serial shift model.

Data changing while the strobe is low, the fixed values from the all-ones seed, the start pulse landing together with a strobe, and a reset arriving in the middle of a packet are shown only by the bench's scenarios. In those scenarios a scoreboard compares `crc_o` against a serial reference model run independently of the design.

// File: rtl/crc5n_pkg.sv
package crc5n_pkg;

   // Selects how the next-state network is built
   typedef enum logic {
      CRC_IMPL_EQN  = 1'b0,   // hand-reduced XOR equations (5-bit / 4-bit only)
      CRC_IMPL_LOOP = 1'b1    // generic unrolled shift steps for any width
   } crc_impl_e;

   localparam int unsigned CRC5_W    = 5;
   localparam int unsigned NIBBLE_W  = 4;
   localparam logic [CRC5_W-1:0] CRC5_POLY = 5'h05;  // x^2 + 1, x^5 implied
   localparam logic [CRC5_W-1:0] CRC5_SEED = 5'h1F;

endpackage

// File: rtl/crc5n_eqn.sv
module crc5n_eqn
   import crc5n_pkg::*;
#(
   parameter int unsigned CRC_W  = CRC5_W,
   parameter int unsigned DATA_W = NIBBLE_W
) (
   input  logic [CRC_W-1:0]  cur_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [CRC_W-1:0]  nxt_o
);

   generate
      if (CRC_W != 5 || DATA_W != 4) begin : g_bad_size
         $error("crc5n_eqn supports only a 5-bit state and a 4-bit data word");
      end
   endgenerate

   // Four serial steps, MSB of the nibble first, collapsed into one level
   always_comb begin
      nxt_o    = '0;
      nxt_o[0] = cur_i[1] ^ cur_i[4] ^ dat_i[0] ^ dat_i[3];
      nxt_o[1] = cur_i[2] ^ dat_i[1];
      nxt_o[2] = cur_i[1] ^ cur_i[3] ^ cur_i[4] ^ dat_i[0] ^ dat_i[2] ^ dat_i[3];
      nxt_o[3] = cur_i[2] ^ cur_i[4] ^ dat_i[1] ^ dat_i[3];
      nxt_o[4] = cur_i[0] ^ cur_i[3] ^ dat_i[2];
   end

endmodule

// File: rtl/crc5n_loop.sv
module crc5n_loop
   import crc5n_pkg::*;
#(
   parameter int unsigned       CRC_W  = CRC5_W,
   parameter int unsigned       DATA_W = NIBBLE_W,
   parameter logic [CRC_W-1:0]  POLY   = CRC5_POLY
) (
   input  logic [CRC_W-1:0]  cur_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [CRC_W-1:0]  nxt_o
);

   localparam int unsigned TOP = CRC_W - 1;

   // DATA_W chained shift stages; the synthesizer flattens the chain
   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = cur_i;

   generate
      for (genvar s = 0; s < DATA_W; s++) begin : g_step
         logic fb;
         assign fb = stage[s][TOP] ^ dat_i[DATA_W-1-s];
         assign stage[s+1] = {stage[s][TOP-1:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate

   assign nxt_o = stage[DATA_W];

endmodule

// File: rtl/crc5n_state.sv
module crc5n_state #(
   parameter int unsigned      CRC_W = 5,
   parameter logic [CRC_W-1:0] SEED  = '1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             init_i,
   input  logic             valid_i,
   input  logic [CRC_W-1:0] nxt_i,
   output logic [CRC_W-1:0] q_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i || init_i) begin
         q_o <= SEED;
      end else if (valid_i) begin
         q_o <= nxt_i;
      end
   end

endmodule

// File: rtl/crc5n_gen.sv
module crc5n_gen
   import crc5n_pkg::*;
#(
   parameter int unsigned      CRC_W  = CRC5_W,
   parameter int unsigned      DATA_W = NIBBLE_W,
   parameter logic [CRC_W-1:0] POLY   = CRC5_POLY,
   parameter logic [CRC_W-1:0] SEED   = CRC5_SEED,
   parameter crc_impl_e        IMPL   = CRC_IMPL_EQN
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              init_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   localparam bit FIXED_SHAPE = (CRC_W == 5) && (DATA_W == 4) && (POLY == 5'h05);

   generate
      if (CRC_W < 2) begin : g_chk_w
         $error("CRC_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_chk_d
         $error("DATA_W must be at least 1");
      end
      if (POLY[0] != 1'b1) begin : g_chk_p
         $error("POLY must have its constant term set");
      end
      if (IMPL == CRC_IMPL_EQN && !FIXED_SHAPE) begin : g_chk_e
         $error("equation variant requires CRC_W=5, DATA_W=4, POLY=5'h05");
      end
   endgenerate

   logic [CRC_W-1:0] state_q;
   logic [CRC_W-1:0] state_d;

   generate
      if (IMPL == CRC_IMPL_EQN) begin : g_eqn
         crc5n_eqn #(
            .CRC_W  (CRC_W),
            .DATA_W (DATA_W)
         ) u_next (
            .cur_i (state_q),
            .dat_i (data_i),
            .nxt_o (state_d)
         );
      end else begin : g_loop
         crc5n_loop #(
            .CRC_W  (CRC_W),
            .DATA_W (DATA_W),
            .POLY   (POLY)
         ) u_next (
            .cur_i (state_q),
            .dat_i (data_i),
            .nxt_o (state_d)
         );
      end
   endgenerate

   crc5n_state #(
      .CRC_W (CRC_W),
      .SEED  (SEED)
   ) u_state (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .init_i  (init_i),
      .valid_i (valid_i),
      .nxt_i   (state_d),
      .q_o     (state_q)
   );

   assign crc_o = state_q;

endmodule

// File: rtl/crc5n_gen_chk.sv
module crc5n_gen_chk #(
   parameter int unsigned      CRC_W  = 5,
   parameter int unsigned      DATA_W = 4,
   parameter logic [CRC_W-1:0] POLY   = 5'h05,
   parameter logic [CRC_W-1:0] SEED   = 5'h1F
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              init_i,
   input logic              valid_i,
   input logic [DATA_W-1:0] data_i,
   input logic [CRC_W-1:0]  crc_o
);

   // Bit-at-a-time model, independent of the collapsed equations
   function automatic logic [CRC_W-1:0] serial_ref(input logic [CRC_W-1:0] c,
                                                   input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] r;
      logic fb;
      r = c;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ d[i];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      return r;
   endfunction

   // R1
   reset_seed_chk: assert property (@(posedge clk_i)
      rst_i |=> (crc_o == SEED));

   // R2
   init_seed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      init_i |=> (crc_o == SEED));

   // R3
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!init_i && !valid_i) |=> $stable(crc_o));

   // R4
   nibble_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!init_i && valid_i) |=> (crc_o == serial_ref($past(crc_o), $past(data_i))));

endmodule

bind crc5n_gen crc5n_gen_chk #(
   .CRC_W  (CRC_W),
   .DATA_W (DATA_W),
   .POLY   (POLY),
   .SEED   (SEED)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .init_i  (init_i),
   .valid_i (valid_i),
   .data_i  (data_i),
   .crc_o   (crc_o)
);

// File: tb/tb_crc5n_gen.sv
`timescale 1ns/1ps
module tb_crc5n_gen;

   logic       clk_i = 1'b0;
   logic       rst_i = 1'b1;
   logic       init_i = 1'b0;
   logic       valid_i = 1'b0;
   logic [3:0] data_i = 4'h0;
   logic [4:0] crc_o;

   int n_checks = 0;
   int n_fails  = 0;
   logic [4:0] model = 5'h1F;

   logic [4:0] exp_q [$];
   string      tag_q [$];

   always #2 clk_i = ~clk_i;   // 250 MHz

   crc5n_gen dut (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .init_i  (init_i),
      .valid_i (valid_i),
      .data_i  (data_i),
      .crc_o   (crc_o)
   );

   // Serial reference: four shifts, data_i[3] first, poly x^5+x^2+1
   function automatic logic [4:0] ser_step(input logic [4:0] c, input logic [3:0] d);
      logic [4:0] r;
      logic fb;
      r = c;
      for (int i = 3; i >= 0; i--) begin
         fb = r[4] ^ d[i];
         r  = {r[3], r[2], r[1] ^ fb, r[0], fb};
      end
      return r;
   endfunction

   task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: crc_o=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: one call per cycle, pushes the value expected after the edge
   task automatic beat(input logic v, input logic ini, input logic [3:0] d, input string req);
      @(negedge clk_i);
      valid_i = v;
      init_i  = ini;
      data_i  = d;
      if (ini)    model = 5'h1F;
      else if (v) model = ser_step(model, d);
      exp_q.push_back(model);
      tag_q.push_back(req);
   endtask

   // Monitor: compares just after each rising edge
   always @(posedge clk_i) begin
      #1;
      if (exp_q.size() > 0) begin
         check(crc_o, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #100000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: crc_o=%h expected=completion", crc_o);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk_i);
      check(crc_o, 5'h1F, "R1 reset seed");
      rst_i = 1'b0;

      // R3 / R7: idle with data changing
      beat(1'b0, 1'b0, 4'hA, "R3 idle hold");
      beat(1'b0, 1'b0, 4'h5, "R7 data ignored");
      beat(1'b0, 1'b0, 4'hF, "R7 data ignored");

      // R5 fixed values from the seed, R6 one-edge latency
      beat(1'b1, 1'b0, 4'h0, "R5 seed+0");
      check(exp_q[0], 5'h06, "R5 model literal 06");
      beat(1'b0, 1'b1, 4'h0, "R2 init");
      beat(1'b1, 1'b0, 4'hF, "R5 seed+F");
      check(exp_q[0], 5'h10, "R5 model literal 10");
      @(negedge clk_i);
      init_i = 1'b0; valid_i = 1'b0;
      check(crc_o, 5'h10, "R6 registered output");

      // R4: every nibble value from several states
      beat(1'b0, 1'b1, 4'h0, "R2 init");
      for (int k = 0; k < 16; k++) beat(1'b1, 1'b0, 4'(k), "R4 nibble sweep");
      for (int k = 0; k < 16; k++) beat(1'b1, 1'b0, 4'(15 - k), "R4 nibble sweep down");

      // R2: init together with valid drops the nibble
      beat(1'b1, 1'b1, 4'h9, "R2 init beats valid");
      beat(1'b1, 1'b0, 4'h3, "R4 after init");

      // R3 gaps between beats
      for (int k = 0; k < 40; k++) begin
         logic [3:0] d;
         d = 4'($urandom);
         beat(1'($urandom), 1'b0, d, "R4 R3 random stream");
      end

      // R1 reset mid-packet
      beat(1'b1, 1'b0, 4'h7, "R4 before reset");
      @(negedge clk_i);
      valid_i = 1'b1; data_i = 4'hC; rst_i = 1'b1;
      @(negedge clk_i);
      check(crc_o, 5'h1F, "R1 reset mid-packet");
      rst_i = 1'b0; valid_i = 1'b0;
      model = 5'h1F;
      beat(1'b1, 1'b0, 4'h0, "R5 after reset");
      beat(1'b0, 1'b0, 4'h0, "R3 final hold");
      repeat (3) @(negedge clk_i);
      summary();
   end

endmodule